// File: doc/BRIEF.md
# Blink-Coded Error Display

This block reports a fault code through a single indicator LED. The code is four base-4 digits. When the unit is in a failure state and a retrieval request arrives, the block reads the code in and plays it out digit by digit, most significant first. Each digit is shown as a burst of blinks whose count is the digit value, and each burst is played twice. A digit of zero is shown as four blinks so that it is still visible. Dark intervals mark where a burst ends and where a digit ends. When the last digit has been shown, the LED goes back to steady on.

All durations come from a slow tick strobe supplied by the surrounding logic. The block holds no clock divider of its own. At the same time, the block outputs the code converted from base-4 to an unsigned value, which an on-screen message path shows after an "E". For example, code 1022 gives 74.

Top module: `blinkErrorDisplay`

## Requirements
- R1: After reset, and whenever no display is in progress, `ledOn` is 1 and `displayBusy` is 0.
- R2: A display starts only on a clock edge where `retrieveReq` and `faultActive` are both 1 while idle. A request while `faultActive` is 0 is ignored, so `displayBusy` stays 0 and `ledOn` stays 1.
- R3: A display opens with a dark lead-in of GAP_TICKS ticks. The digits then follow from digit 3 (`errCode[7:6]`) down to digit 0 (`errCode[1:0]`).
- R4: A digit of value v in 1..3 is shown as v blinks. Each blink is lit for ON_TICKS ticks. Consecutive blinks in a burst are separated by OFF_TICKS dark ticks.
- R5: A digit of value 0 is shown as four blinks.
- R6: Every digit's burst is shown twice. A dark pause of PAUSE_TICKS ticks follows the first burst.
- R7: A dark gap of GAP_TICKS ticks follows the second burst. The next digit then starts. After the gap of digit 0, the block returns to idle with the LED steady on.
- R8: The code is captured when the display starts. Changes on `errCode` and further requests during a display do not alter the blink sequence.
- R9: `decimalCode` equals d3*64 + d2*16 + d1*4 + d0 of the `errCode` sampled at the previous clock edge, where dk = `errCode[2k+1:2k]` (for example, 1022 gives 74). Its reset value is 0.
- R10: `ledOn` and `displayBusy` change only on edges where `tick` is 1. The single exception is the edge that starts a display.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle timing strobe that paces all display phases |
| faultActive | input | 1 | Unit is in a failure state; enables retrieval |
| retrieveReq | input | 1 | Request to play the code out on the LED |
| errCode | input | 8 | Four base-4 digits, digit 3 in bits 7:6 |
| ledOn | output | 1 | Indicator drive, 1 = lit |
| displayBusy | output | 1 | A code display is in progress |
| decimalCode | output | 8 | Code converted from base-4, for the "E nn" message |

## Verification
The bench builds the block with ON_TICKS=2, OFF_TICKS=1, PAUSE_TICKS=3 and GAP_TICKS=4, and drives a tick every third clock. With these values, a whole four-digit display of four-blink zeros lasts about 120 ticks. Every blink, pause and gap boundary can therefore be compared tick by tick across many codes. Because the pause and gap lengths differ, a pause swapped for a gap shows up as a wrong sample. Because ON and OFF differ, swapped blink phases are visible too.

// File: rtl/blinkDisplayPkg.sv
package blinkDisplayPkg;

  typedef enum logic [1:0] {
    DUR_ON,
    DUR_OFF,
    DUR_PAUSE,
    DUR_GAP
  } durSel_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_ON,
    ST_OFF,
    ST_PAUSE,
    ST_GAP
  } dispState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    startSeq;      // capture code, point at top digit
    logic    loadTimer;     // load phase timer with durSel
    durSel_t durSel;
    logic    reloadBlinks;  // restart burst of current digit
    logic    countBlink;    // one blink of the burst finished
    logic    stepDigit;     // advance to next lower digit
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic timerDone;
    logic lastBlink;
    logic lastDigit;
  } dpStatus_t;

endpackage

// File: rtl/blinkDatapath.sv
module blinkDatapath
  import blinkDisplayPkg::*;
#(
  parameter int NUM_DIGITS  = 4,
  parameter int DIGIT_W     = 2,
  parameter int ON_TICKS    = 4,
  parameter int OFF_TICKS   = 4,
  parameter int PAUSE_TICKS = 12,
  parameter int GAP_TICKS   = 24
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          tick,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] codeIn,
  input  ctrlStrobe_t                   strobe,
  output dpStatus_t                     status,
  output logic [NUM_DIGITS*DIGIT_W-1:0] decimalOut
);

  localparam int CODE_W  = NUM_DIGITS * DIGIT_W;
  localparam int RADIX   = 1 << DIGIT_W;
  localparam int CNT_W   = DIGIT_W + 1;
  localparam int IDX_W   = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
  localparam int MAX_A   = (ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS;
  localparam int MAX_B   = (PAUSE_TICKS > GAP_TICKS) ? PAUSE_TICKS : GAP_TICKS;
  localparam int MAX_DUR = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W   = $clog2(MAX_DUR + 1);

  logic [CODE_W-1:0]  codeReg;
  logic [IDX_W-1:0]   digitIdx;
  logic [CNT_W-1:0]   blinksLeft;
  logic [TMR_W-1:0]   phaseTimer;
  logic [TMR_W-1:0]   durValue;
  logic [DIGIT_W-1:0] heldDigit [NUM_DIGITS];
  logic [DIGIT_W-1:0] liveDigit [NUM_DIGITS];
  logic [CODE_W-1:0]  weighted  [NUM_DIGITS];
  logic [CODE_W-1:0]  decSum;
  logic [IDX_W-1:0]   lowerIdx;

  // zero is shown as a full-radix burst so it stays visible
  function automatic logic [CNT_W-1:0] burstLen(input logic [DIGIT_W-1:0] d);
    return (d == '0) ? CNT_W'(RADIX) : CNT_W'(d);
  endfunction

  genvar g;
  generate
    for (g = 0; g < NUM_DIGITS; g++) begin : gDigit
      assign heldDigit[g] = codeReg[g*DIGIT_W +: DIGIT_W];
      assign liveDigit[g] = codeIn[g*DIGIT_W +: DIGIT_W];
      assign weighted[g]  = CODE_W'(liveDigit[g]) << (g * DIGIT_W);
    end
  endgenerate

  always_comb begin
    decSum = '0;
    for (int i = 0; i < NUM_DIGITS; i++) decSum = decSum + weighted[i];
  end

  always_comb begin
    unique case (strobe.durSel)
      DUR_ON:    durValue = TMR_W'(ON_TICKS);
      DUR_OFF:   durValue = TMR_W'(OFF_TICKS);
      DUR_PAUSE: durValue = TMR_W'(PAUSE_TICKS);
      default:   durValue = TMR_W'(GAP_TICKS);
    endcase
  end

  assign lowerIdx = digitIdx - 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeReg    <= '0;
      digitIdx   <= '0;
      blinksLeft <= '0;
    end else if (strobe.startSeq) begin
      codeReg    <= codeIn;
      digitIdx   <= IDX_W'(NUM_DIGITS - 1);
      blinksLeft <= burstLen(liveDigit[NUM_DIGITS-1]);
    end else if (strobe.stepDigit) begin
      digitIdx   <= lowerIdx;
      blinksLeft <= burstLen(heldDigit[lowerIdx]);
    end else if (strobe.reloadBlinks) begin
      blinksLeft <= burstLen(heldDigit[digitIdx]);
    end else if (strobe.countBlink) begin
      blinksLeft <= blinksLeft - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseTimer <= '0;
    end else if (strobe.loadTimer) begin
      phaseTimer <= durValue;
    end else if (tick && (phaseTimer != '0)) begin
      phaseTimer <= phaseTimer - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) decimalOut <= '0;
    else       decimalOut <= decSum;
  end

  assign status.timerDone = tick && (phaseTimer == TMR_W'(1));
  assign status.lastBlink = (blinksLeft == CNT_W'(1));
  assign status.lastDigit = (digitIdx == '0);

endmodule

// File: rtl/blinkControl.sv
module blinkControl
  import blinkDisplayPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        faultActive,
  input  logic        retrieveReq,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        ledOn,
  output logic        displayBusy
);

  dispState_t state, stateNext;
  logic       secondBurst, secondBurstNext;

  always_comb begin
    stateNext       = state;
    secondBurstNext = secondBurst;
    strobe          = '0;
    unique case (state)
      ST_IDLE: begin
        if (retrieveReq && faultActive) begin
          strobe.startSeq  = 1'b1;
          strobe.loadTimer = 1'b1;
          strobe.durSel    = DUR_GAP;
          secondBurstNext  = 1'b0;
          stateNext        = ST_LEAD;
        end
      end
      ST_LEAD: begin
        if (status.timerDone) begin
          strobe.loadTimer = 1'b1;
          strobe.durSel    = DUR_ON;
          stateNext        = ST_ON;
        end
      end
      ST_ON: begin
        if (status.timerDone) begin
          strobe.loadTimer = 1'b1;
          if (!status.lastBlink) begin
            strobe.durSel     = DUR_OFF;
            strobe.countBlink = 1'b1;
            stateNext         = ST_OFF;
          end else if (!secondBurst) begin
            strobe.durSel = DUR_PAUSE;
            stateNext     = ST_PAUSE;
          end else begin
            strobe.durSel = DUR_GAP;
            stateNext     = ST_GAP;
          end
        end
      end
      ST_OFF: begin
        if (status.timerDone) begin
          strobe.loadTimer = 1'b1;
          strobe.durSel    = DUR_ON;
          stateNext        = ST_ON;
        end
      end
      ST_PAUSE: begin
        if (status.timerDone) begin
          strobe.loadTimer    = 1'b1;
          strobe.durSel       = DUR_ON;
          strobe.reloadBlinks = 1'b1;
          secondBurstNext     = 1'b1;
          stateNext           = ST_ON;
        end
      end
      ST_GAP: begin
        if (status.timerDone) begin
          if (status.lastDigit) begin
            stateNext = ST_IDLE;
          end else begin
            strobe.loadTimer = 1'b1;
            strobe.durSel    = DUR_ON;
            strobe.stepDigit = 1'b1;
            secondBurstNext  = 1'b0;
            stateNext        = ST_ON;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      secondBurst <= 1'b0;
    end else begin
      state       <= stateNext;
      secondBurst <= secondBurstNext;
    end
  end

  assign ledOn       = (state == ST_IDLE) || (state == ST_ON);
  assign displayBusy = (state != ST_IDLE);

endmodule

// File: rtl/blinkErrorDisplay.sv
module blinkErrorDisplay
  import blinkDisplayPkg::*;
#(
  parameter int NUM_DIGITS  = 4,
  parameter int DIGIT_W     = 2,
  parameter int ON_TICKS    = 4,
  parameter int OFF_TICKS   = 4,
  parameter int PAUSE_TICKS = 12,
  parameter int GAP_TICKS   = 24
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          tick,
  input  logic                          faultActive,
  input  logic                          retrieveReq,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] errCode,
  output logic                          ledOn,
  output logic                          displayBusy,
  output logic [NUM_DIGITS*DIGIT_W-1:0] decimalCode
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  blinkControl i_control (
    .clk         (clk),
    .rstN        (rstN),
    .faultActive (faultActive),
    .retrieveReq (retrieveReq),
    .status      (status),
    .strobe      (strobe),
    .ledOn       (ledOn),
    .displayBusy (displayBusy)
  );

  blinkDatapath #(
    .NUM_DIGITS  (NUM_DIGITS),
    .DIGIT_W     (DIGIT_W),
    .ON_TICKS    (ON_TICKS),
    .OFF_TICKS   (OFF_TICKS),
    .PAUSE_TICKS (PAUSE_TICKS),
    .GAP_TICKS   (GAP_TICKS)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .codeIn     (errCode),
    .strobe     (strobe),
    .status     (status),
    .decimalOut (decimalCode)
  );

endmodule

// File: rtl/blinkDisplayChecker.sv
module blinkDisplayChecker #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              faultActive,
  input logic              retrieveReq,
  input logic [CODE_W-1:0] errCode,
  input logic              ledOn,
  input logic              displayBusy,
  input logic [CODE_W-1:0] decimalCode
);

  logic startCond;
  assign startCond = !displayBusy && retrieveReq && faultActive;

  a_r1_idle_led_on: assert property (@(posedge clk) disable iff (!rstN)
    !displayBusy |-> ledOn);

  a_r2_start_accepted: assert property (@(posedge clk) disable iff (!rstN)
    startCond |=> displayBusy);

  a_r2_no_fault_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!displayBusy && retrieveReq && !faultActive) |=> !displayBusy);

  a_r3_lead_dark: assert property (@(posedge clk) disable iff (!rstN)
    $rose(displayBusy) |-> !ledOn);

  // R9: base-4 digits packed two bits each give the same unsigned value
  a_r9_decimal: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (decimalCode == $past(errCode)));

  a_r10_tick_paced: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !startCond) |=> ($stable(ledOn) && $stable(displayBusy)));

endmodule

bind blinkErrorDisplay blinkDisplayChecker #(
  .CODE_W (NUM_DIGITS*DIGIT_W)
) i_checker (
  .clk         (clk),
  .rstN        (rstN),
  .tick        (tick),
  .faultActive (faultActive),
  .retrieveReq (retrieveReq),
  .errCode     (errCode),
  .ledOn       (ledOn),
  .displayBusy (displayBusy),
  .decimalCode (decimalCode)
);

// File: tb/test_blinkErrorDisplay.sv
module test_blinkErrorDisplay;

  localparam int CLK_PERIOD = 10;
  localparam int T_ON    = 2;
  localparam int T_OFF   = 1;
  localparam int T_PAUSE = 3;
  localparam int T_GAP   = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       faultActive = 1'b0;
  logic       retrieveReq = 1'b0;
  logic [7:0] errCode = '0;
  logic       ledOn;
  logic       displayBusy;
  logic [7:0] decimalCode;

  int  checks = 0;
  int  fails = 0;
  bit  finished = 1'b0;
  bit  expLed [0:511];
  int  expLen;

  blinkErrorDisplay #(
    .NUM_DIGITS  (4),
    .DIGIT_W     (2),
    .ON_TICKS    (T_ON),
    .OFF_TICKS   (T_OFF),
    .PAUSE_TICKS (T_PAUSE),
    .GAP_TICKS   (T_GAP)
  ) i_blinkErrorDisplay (
    .clk         (clk),
    .rstN        (rstN),
    .tick        (tick),
    .faultActive (faultActive),
    .retrieveReq (retrieveReq),
    .errCode     (errCode),
    .ledOn       (ledOn),
    .displayBusy (displayBusy),
    .decimalCode (decimalCode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      repeat (2) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int decModel(input logic [7:0] c);
    return c[7:6]*64 + c[5:4]*16 + c[3:2]*4 + c[1:0];
  endfunction

  task automatic pushRun(inout int p, input bit v, input int n);
    for (int k = 0; k < n; k++) begin
      expLed[p] = v;
      p++;
    end
  endtask

  // expected LED level per tick interval, position 0 = start edge
  task automatic buildStream(input logic [7:0] c);
    int p = 0;
    pushRun(p, 1'b0, T_GAP);                       // R3 lead-in
    for (int d = 3; d >= 0; d--) begin
      int v = (c >> (2*d)) & 3;
      int n = (v == 0) ? 4 : v;                    // R5
      for (int rep = 0; rep < 2; rep++) begin      // R6
        for (int b = 0; b < n; b++) begin          // R4
          pushRun(p, 1'b1, T_ON);
          if (b < n - 1) pushRun(p, 1'b0, T_OFF);
        end
        pushRun(p, 1'b0, (rep == 0) ? T_PAUSE : T_GAP);  // R6 / R7
      end
    end
    expLen = p;
    expLed[p] = 1'b1;
  endtask

  task automatic runDisplay(input logic [7:0] c, input int noiseAt);
    buildStream(c);
    @(negedge clk);
    errCode = c;
    faultActive = 1'b1;
    retrieveReq = 1'b1;
    @(posedge clk);
    #1;
    retrieveReq = 1'b0;
    check(displayBusy == 1'b1, "R2 start busy", displayBusy, 1);
    check(ledOn == 1'b0, "R3 lead-in dark", ledOn, 0);
    for (int j = 1; j <= expLen; j++) begin
      forever begin
        @(posedge clk);
        if (tick) break;
      end
      #1;
      check(ledOn == expLed[j], "R4 R5 R6 R7 blink pattern", ledOn, expLed[j]);
      check(displayBusy == (j < expLen), "R7 busy span", displayBusy, (j < expLen));
      if (j == noiseAt) begin          // R8 disturbances during display
        retrieveReq = 1'b1;
        errCode = ~c;
      end
      if (j == noiseAt + 2) retrieveReq = 1'b0;
    end
    retrieveReq = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    check(ledOn == 1'b1 && displayBusy == 1'b0, "R7 R1 steady after end", ledOn, 1);
  endtask

  task automatic checkDec(input logic [7:0] c);
    @(negedge clk);
    errCode = c;
    @(posedge clk);
    #1;
    check(decimalCode == 8'(decModel(c)), "R9 decimal", decimalCode, decModel(c));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check(ledOn == 1'b1, "R1 reset led", ledOn, 1);
    check(displayBusy == 1'b0, "R1 reset busy", displayBusy, 0);
    check(decimalCode == 8'd0, "R9 reset decimal", decimalCode, 0);
    @(negedge clk);
    rstN = 1'b1;

    // R9 directed and random conversions
    checkDec(8'b01_00_10_10);   // 1022 -> 74
    checkDec(8'b11_11_11_11);   // 3333 -> 255
    checkDec(8'b00_00_00_00);
    for (int i = 0; i < 12; i++) checkDec(8'($urandom));

    // R2: request without fault is ignored
    @(negedge clk);
    faultActive = 1'b0;
    retrieveReq = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    retrieveReq = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk);
      #1;
      check(displayBusy == 1'b0 && ledOn == 1'b1, "R2 no fault ignored", displayBusy, 0);
    end

    // directed displays
    runDisplay(8'b01_00_10_10, 0);   // 1022
    runDisplay(8'b00_00_00_00, 7);   // all zero digits, R5; R8 noise
    runDisplay(8'b11_11_11_11, 30);  // R8 noise
    runDisplay(8'b00_01_10_11, 0);

    // random displays with random disturbances
    for (int i = 0; i < 8; i++) begin
      logic [7:0] c = 8'($urandom);
      runDisplay(c, 1 + ($urandom % 40));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule